// File: doc/BRIEF.md
# Triggered Sine Controller

This block sequences a multi-channel sine synthesizer through one iteration of configuration and triggered running. A Start pulse makes it load the synthesizer's phase-increment register and then its phase-offset register, one clock each, by raising a write enable with a register select of 0 and then 1. It then parks with the synthesizer cleared until the first trigger arrives. From that trigger on, the channels run with their clock enable high.

Every later trigger makes the controller spend exactly one clock in a phase-reset state, where both clock enable and synchronous clear are high, so all channels restart from their initial phase. A Stop pulse ends the iteration from any state and returns the controller to idle. The current state is always visible as a 3-bit code. All outputs are registered and change on the same edge as the state code.

Top module: `sseq_ctl`

## Requirements
- R1: Synchronous active-high reset gives state code 000 and wr_en_o=0, reg_sel_o=0, clk_en_o=0, sync_clr_o=1 on the cycle after the reset edge.
- R2: A start_i pulse in idle (000), without stop_i, moves to increment-config (001), where wr_en_o=1 and reg_sel_o=0. In every other state start_i has no effect.
- R3: Increment-config lasts one clock and is followed by offset-config (010), where wr_en_o=1 and reg_sel_o=1, whatever start_i and trig_i do.
- R4: Offset-config lasts one clock and is followed by wait-for-trigger (011). This state holds with clk_en_o=0, sync_clr_o=1 and wr_en_o=0 until a trigger arrives.
- R5: A trig_i pulse in wait-for-trigger enters run (100), where clk_en_o=1 and sync_clr_o=0. Run holds while no trigger or stop arrives.
- R6: A trig_i pulse in run enters phase-reset (101), where clk_en_o=1 and sync_clr_o=1. Phase-reset always lasts exactly one clock and returns to run, even when trig_i is high in it.
- R7: stop_i in any state gives idle (000) with the idle output values on the next cycle. stop_i takes priority over start_i and trig_i arriving in the same cycle.
- R8: state_o shows only the six codes 000, 001, 010, 011, 100 and 101. wr_en_o is high only in codes 001 and 010, and clk_en_o is high only in codes 100 and 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an iteration (single-cycle pulse) |
| stop_i | input | 1 | End the current iteration (single-cycle pulse) |
| trig_i | input | 1 | Trigger pulse |
| wr_en_o | output | 1 | Write enable for the synthesizer configuration registers |
| reg_sel_o | output | 1 | Register select: 0 = phase increment, 1 = phase offset |
| clk_en_o | output | 1 | Clock enable for the synthesizer channels |
| sync_clr_o | output | 1 | Synchronous clear, holds channels at their initial phase |
| state_o | output | 3 | Current state code |

## Verification
The assertions assume that start_i, stop_i and trig_i are synchronous to clk and are sampled only at rising edges. They place no limit on how pulses overlap, so any combination of the three in any state must give a legal next state. The stimulus changes inputs only on falling edges. It walks the machine into each of the six states by a known path and then applies all eight combinations of the three inputs there. This covers every overlap, including Stop against Start or a trigger.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'b000,
    ST_INC   = 3'b001,
    ST_OFF   = 3'b010,
    ST_WAIT  = 3'b011,
    ST_RUN   = 3'b100,
    ST_PRST  = 3'b101
  } sseq_state_e;

  typedef struct packed {
    logic we;
    logic sel;
    logic ce;
    logic clr;
  } sseq_ctl_t;

  localparam sseq_ctl_t CTL_IDLE = '{we: 1'b0, sel: 1'b0, ce: 1'b0, clr: 1'b1};
endpackage

// File: rtl/sseq_next.sv
module sseq_next
  import sseq_pkg::*;
(
  input  sseq_state_e cur_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        trig_i,
  output sseq_state_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (stop_i) begin
      nxt_o = ST_IDLE;
    end else begin
      unique case (cur_i)
        ST_IDLE: if (start_i) nxt_o = ST_INC;
        ST_INC:  nxt_o = ST_OFF;
        ST_OFF:  nxt_o = ST_WAIT;
        ST_WAIT: if (trig_i) nxt_o = ST_RUN;
        ST_RUN:  if (trig_i) nxt_o = ST_PRST;
        ST_PRST: nxt_o = ST_RUN;
        default: nxt_o = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sseq_decode.sv
module sseq_decode
  import sseq_pkg::*;
(
  input  sseq_state_e st_i,
  output sseq_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = CTL_IDLE;
    unique case (st_i)
      ST_INC:  ctl_o = '{we: 1'b1, sel: 1'b0, ce: 1'b0, clr: 1'b1};
      ST_OFF:  ctl_o = '{we: 1'b1, sel: 1'b1, ce: 1'b0, clr: 1'b1};
      ST_RUN:  ctl_o = '{we: 1'b0, sel: 1'b0, ce: 1'b1, clr: 1'b0};
      ST_PRST: ctl_o = '{we: 1'b0, sel: 1'b0, ce: 1'b1, clr: 1'b1};
      default: ctl_o = CTL_IDLE;
    endcase
  end
endmodule

// File: rtl/sseq_ctl.sv
module sseq_ctl
  import sseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               trig_i,
  output logic               wr_en_o,
  output logic               reg_sel_o,
  output logic               clk_en_o,
  output logic               sync_clr_o,
  output logic [STATE_W-1:0] state_o
);
  sseq_state_e st_q, st_d;
  sseq_ctl_t   ctl_d, ctl_q;

  sseq_next u_next (
    .cur_i  (st_q),
    .start_i(start_i),
    .stop_i (stop_i),
    .trig_i (trig_i),
    .nxt_o  (st_d)
  );

  // Outputs are decoded from the next state and registered alongside it,
  // so they line up with the state code without a combinational path out.
  sseq_decode u_dec (
    .st_i (st_d),
    .ctl_o(ctl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      ctl_q <= CTL_IDLE;
    end else begin
      st_q  <= st_d;
      ctl_q <= ctl_d;
    end
  end

  assign state_o    = st_q;
  assign wr_en_o    = ctl_q.we;
  assign reg_sel_o  = ctl_q.sel;
  assign clk_en_o   = ctl_q.ce;
  assign sync_clr_o = ctl_q.clr;
endmodule

// File: rtl/sseq_ctl_chk.sv
module sseq_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       stop_i,
  input logic       trig_i,
  input logic       wr_en_o,
  input logic       reg_sel_o,
  input logic       clk_en_o,
  input logic       sync_clr_o,
  input logic [2:0] state_o
);
  logic rst_seen_q;

  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst_seen_q) begin
      // R1
      reset_idle_chk: assert (state_o == 3'b000 && !wr_en_o && !clk_en_o && sync_clr_o);
    end
  end

  // R2
  start_enters_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b000 && start_i && !stop_i) |=> (state_o == 3'b001 && wr_en_o && !reg_sel_o));

  // R3
  inc_to_off_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b001 && !stop_i) |=> (state_o == 3'b010 && wr_en_o && reg_sel_o));

  // R4
  off_to_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b010 && !stop_i) |=> (state_o == 3'b011 && !clk_en_o && sync_clr_o));

  // R5
  wait_trig_run_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b011 && trig_i && !stop_i) |=> (state_o == 3'b100 && clk_en_o && !sync_clr_o));

  // R6
  run_trig_prst_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b100 && trig_i && !stop_i) |=> (state_o == 3'b101 && clk_en_o && sync_clr_o));

  // R6
  prst_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b101 && !stop_i) |=> (state_o == 3'b100));

  // R7
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (state_o == 3'b000 && !wr_en_o && !clk_en_o && sync_clr_o));

  // R8
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o <= 3'b101));

  // R8
  we_scope_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (state_o == 3'b001 || state_o == 3'b010));

  // R8
  ce_scope_chk: assert property (@(posedge clk) disable iff (rst)
    clk_en_o |-> (state_o == 3'b100 || state_o == 3'b101));
endmodule

bind sseq_ctl sseq_ctl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .trig_i    (trig_i),
  .wr_en_o   (wr_en_o),
  .reg_sel_o (reg_sel_o),
  .clk_en_o  (clk_en_o),
  .sync_clr_o(sync_clr_o),
  .state_o   (state_o)
);

// File: tb/sim_sseq_ctl.sv
module sim_sseq_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, trig_i = 1'b0;
  logic wr_en_o, reg_sel_o, clk_en_o, sync_clr_o;
  logic [2:0] state_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sseq_ctl u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .trig_i(trig_i),
    .wr_en_o(wr_en_o), .reg_sel_o(reg_sel_o), .clk_en_o(clk_en_o),
    .sync_clr_o(sync_clr_o), .state_o(state_o)
  );

  // Expected outputs {we, sel, ce, clr} per state code, from the requirements.
  function automatic logic [3:0] exp_out(input logic [2:0] s);
    case (s)
      3'd1: return 4'b1001;
      3'd2: return 4'b1101;
      3'd4: return 4'b0010;
      3'd5: return 4'b0011;
      default: return 4'b0001;
    endcase
  endfunction

  // Expected next code for state s with inputs c = {start, stop, trig}.
  function automatic logic [2:0] exp_next(input logic [2:0] s, input logic [2:0] c);
    if (c[1]) return 3'd0;
    case (s)
      3'd0: return c[2] ? 3'd1 : 3'd0;
      3'd1: return 3'd2;
      3'd2: return 3'd3;
      3'd3: return c[0] ? 3'd4 : 3'd3;
      3'd4: return c[0] ? 3'd5 : 3'd4;
      default: return 3'd4;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] s, input logic [2:0] c);
    if (c[1]) return "R7";
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return c[0] ? "R5" : "R4";
      3'd4: return c[0] ? "R6" : "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic cyc(input logic s, input logic p, input logic t);
    @(negedge clk);
    start_i = s; stop_i = p; trig_i = t;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start_i = 1'b0; stop_i = 1'b0; trig_i = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check(input string req, input logic [2:0] es);
    logic [6:0] got, exp;
    got = {state_o, wr_en_o, reg_sel_o, clk_en_o, sync_clr_o};
    exp = {es, exp_out(es)};
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got state/we/sel/ce/clr %b expected %b", req, got, exp);
    end
  endtask

  // Walk from idle to the state with code s along a fixed path.
  task automatic goto(input logic [2:0] s);
    do_reset();
    case (s)
      3'd1: cyc(1, 0, 0);
      3'd2: begin cyc(1, 0, 0); cyc(0, 0, 0); end
      3'd3: begin cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0); end
      3'd4: begin cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 1); end
      3'd5: begin cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 1); cyc(0, 0, 1); end
      default: ;
    endcase
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    #1;
    check("R1", 3'd0);

    // R8 and R2..R7: every state against every input combination
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < 8; c++) begin
        goto(3'(s));
        check("R8", 3'(s));
        cyc(c[2], c[1], c[0]);
        check(req_of(3'(s), 3'(c)), exp_next(3'(s), 3'(c)));
      end
    end

    // R4: wait-for-trigger holds across many idle cycles
    goto(3'd3);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0);
    check("R4", 3'd3);

    // R5: run holds, start ignored there
    cyc(0, 0, 1);
    for (int i = 0; i < 10; i++) cyc(i[0], 0, 0);
    check("R5", 3'd4);

    // R6: repeated triggers alternate run and phase-reset
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 1);
      check("R6", 3'd5);
      cyc(0, 0, 0);
      check("R6", 3'd4);
    end

    // R7: stop then a fresh iteration restarts configuration
    cyc(0, 1, 0);
    check("R7", 3'd0);
    cyc(1, 0, 0);
    check("R2", 3'd1);
    cyc(0, 0, 0);
    check("R3", 3'd2);

    // R1: reset in mid-run returns to idle
    cyc(0, 0, 0);
    cyc(0, 0, 1);
    do_reset();
    check("R1", 3'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule